// File: doc/BRIEF.md
# Raster Timing Generator

This block keeps the beam position for a tile-based video processor. It counts dots along a scanline and scanlines down a frame. A clock-enable input advances it by one dot. Its outputs are the current dot and line numbers, a flag that marks the visible pixel window, and three frame events: a one-cycle strobe when the last visible line is finished, a vertical-blank flag, and a one-cycle interrupt request.

The vertical-blank flag goes high when the line count enters the blanking line. It stays high until a status-read clear pulse arrives or the frame wraps back to line 0. The host side supplies two inputs: the interrupt enable as a level, and the status-read clear as a one-cycle pulse. Register decoding and pixel generation happen elsewhere.

Top module: `raster_timer`

## Requirements
- R1: While `ce` is high the dot count rises by one on each clock edge. While `ce` is low, dot and line hold their values.
- R2: A line has 341 dots, numbered 0 to 340. On an enabled edge at dot 340 the dot count returns to 0 and the line count rises by one.
- R3: Lines are numbered 0 to 260. An enabled edge at dot 340 of line 260 returns both counts to 0. Line 261 never appears on `line`.
- R4: `frame_done` is high for exactly one cycle: the cycle in which `line` first reads 240, with `dot` at 0.
- R5: `vblank` goes high in the cycle in which `line` first reads 241. In that same cycle `nmi_req` is high for one cycle if `nmi_en` was high at the edge, and it stays low otherwise.
- R6: If `rd_clr` is high at an edge, `vblank` reads 0 after that edge. The exception is an edge that sets `vblank` (R5): then the set wins and `vblank` reads 1.
- R7: The edge that wraps the line count from 260 to 0 also clears `vblank`.
- R8: `visible` is high exactly when `line` is below 240 and `dot` is between 1 and 256 inclusive.
- R9: A synchronous active-high `rst` sets dot and line to 0 and sets `vblank`, `nmi_req` and `frame_done` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ce | input | 1 | Dot advance enable |
| nmi_en | input | 1 | Interrupt enable level |
| rd_clr | input | 1 | Status-read clear pulse for the vertical-blank flag |
| dot | output | 9 | Current dot within the line (0..340) |
| line | output | 9 | Current scanline (0..260) |
| visible | output | 1 | Position is inside the visible pixel window |
| frame_done | output | 1 | One-cycle strobe when the visible area is complete |
| vblank | output | 1 | Vertical-blank flag |
| nmi_req | output | 1 | One-cycle interrupt request at the start of vertical blank |

## Verification
On every cycle the assertions check the counting rules: dot and line hold or step, both wrap at their limits, the line stays in range, the strobe lasts one cycle, the flag reacts to its set and clear events, and an interrupt request never appears without the flag. Only the bench scenarios can show where the events fall in absolute terms. They confirm that the strobe lands on line 240, that the flag and request appear on line 241, that a clear and a set on the same edge leave the flag high, that the wrap clears the flag, and the exact bounds of the visible window.

// File: rtl/raster_pkg.sv
package raster_pkg;

    localparam int unsigned DEF_DOTS      = 341;
    localparam int unsigned DEF_LINES     = 261;
    localparam int unsigned DEF_VIS_LINES = 240;
    localparam int unsigned DEF_VBL_LINE  = 241;
    localparam int unsigned DEF_PIX_FIRST = 1;
    localparam int unsigned DEF_PIX_LAST  = 256;

    typedef struct packed {
        logic frame_end;
        logic vbl_start;
        logic frame_wrap;
    } raster_evt_t;

    function automatic logic in_range(input int unsigned v,
                                      input int unsigned lo,
                                      input int unsigned hi);
        return (v >= lo) && (v <= hi);
    endfunction

endpackage

// File: rtl/raster_dot_ctr.sv
module raster_dot_ctr #(
    parameter int unsigned DOTS = raster_pkg::DEF_DOTS,
    localparam int unsigned DW  = $clog2(DOTS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ce,
    output logic [DW-1:0] dot,
    output logic          line_adv
);

    localparam logic [DW-1:0] LAST = DW'(DOTS - 1);

    logic [DW-1:0] dot_q;

    assign line_adv = ce && (dot_q == LAST);
    assign dot      = dot_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            dot_q <= '0;
        end else if (ce) begin
            dot_q <= (dot_q == LAST) ? '0 : dot_q + 1'b1;
        end
    end

    p_hold_r1: assert property (@(posedge clk) disable iff (rst)
        !ce |=> $stable(dot_q));
    p_step_r1: assert property (@(posedge clk) disable iff (rst)
        (ce && dot_q != LAST) |=> dot_q == DW'($past(dot_q) + 1'b1));
    p_wrap_r2: assert property (@(posedge clk) disable iff (rst)
        (ce && dot_q == LAST) |=> dot_q == '0);

endmodule

// File: rtl/raster_line_ctr.sv
module raster_line_ctr
    import raster_pkg::*;
#(
    parameter int unsigned LINES     = DEF_LINES,
    parameter int unsigned VIS_LINES = DEF_VIS_LINES,
    parameter int unsigned VBL_LINE  = DEF_VBL_LINE,
    localparam int unsigned LW       = $clog2(LINES)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          adv,
    output logic [LW-1:0] line,
    output raster_evt_t   evt
);

    localparam logic [LW-1:0] LAST     = LW'(LINES - 1);
    localparam logic [LW-1:0] PRE_DONE = LW'(VIS_LINES - 1);
    localparam logic [LW-1:0] PRE_VBL  = LW'(VBL_LINE - 1);

    logic [LW-1:0] line_q;
    logic          frame_end_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            line_q      <= '0;
            frame_end_q <= 1'b0;
        end else begin
            frame_end_q <= adv && (line_q == PRE_DONE);
            if (adv) begin
                line_q <= (line_q == LAST) ? '0 : line_q + 1'b1;
            end
        end
    end

    assign line           = line_q;
    assign evt.frame_end  = frame_end_q;
    assign evt.vbl_start  = adv && (line_q == PRE_VBL);
    assign evt.frame_wrap = adv && (line_q == LAST);

    p_line_inc_r2: assert property (@(posedge clk) disable iff (rst)
        (adv && line_q != LAST) |=> line_q == LW'($past(line_q) + 1'b1));
    p_line_wrap_r3: assert property (@(posedge clk) disable iff (rst)
        (adv && line_q == LAST) |=> line_q == '0);
    p_line_range_r3: assert property (@(posedge clk) disable iff (rst)
        line_q <= LAST);
    p_line_hold_r1: assert property (@(posedge clk) disable iff (rst)
        !adv |=> $stable(line_q));
    p_strobe_once_r4: assert property (@(posedge clk) disable iff (rst)
        frame_end_q |=> !frame_end_q);
    p_strobe_line_r4: assert property (@(posedge clk) disable iff (rst)
        frame_end_q |-> line_q == LW'(VIS_LINES));

endmodule

// File: rtl/raster_vblank.sv
module raster_vblank (
    input  logic clk,
    input  logic rst,
    input  logic vbl_start,
    input  logic frame_wrap,
    input  logic rd_clr,
    input  logic nmi_en,
    output logic flag,
    output logic nmi
);

    logic flag_q;
    logic nmi_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
            nmi_q  <= 1'b0;
        end else begin
            nmi_q <= vbl_start && nmi_en;
            if (vbl_start) begin
                flag_q <= 1'b1;
            end else if (rd_clr || frame_wrap) begin
                flag_q <= 1'b0;
            end
        end
    end

    assign flag = flag_q;
    assign nmi  = nmi_q;

    p_set_r5: assert property (@(posedge clk) disable iff (rst)
        vbl_start |=> flag_q);
    p_nmi_flag_r5: assert property (@(posedge clk) disable iff (rst)
        nmi_q |-> flag_q);
    p_nmi_gate_r5: assert property (@(posedge clk) disable iff (rst)
        (vbl_start && !nmi_en) |=> !nmi_q);
    p_clear_r6: assert property (@(posedge clk) disable iff (rst)
        (rd_clr && !vbl_start) |=> !flag_q);
    p_wrap_clear_r7: assert property (@(posedge clk) disable iff (rst)
        (frame_wrap && !vbl_start) |=> !flag_q);

endmodule

// File: rtl/raster_timer.sv
module raster_timer
    import raster_pkg::*;
#(
    parameter int unsigned DOTS      = DEF_DOTS,
    parameter int unsigned LINES     = DEF_LINES,
    parameter int unsigned VIS_LINES = DEF_VIS_LINES,
    parameter int unsigned VBL_LINE  = DEF_VBL_LINE,
    parameter int unsigned PIX_FIRST = DEF_PIX_FIRST,
    parameter int unsigned PIX_LAST  = DEF_PIX_LAST,
    localparam int unsigned DW       = $clog2(DOTS),
    localparam int unsigned LW       = $clog2(LINES)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ce,
    input  logic          nmi_en,
    input  logic          rd_clr,
    output logic [DW-1:0] dot,
    output logic [LW-1:0] line,
    output logic          visible,
    output logic          frame_done,
    output logic          vblank,
    output logic          nmi_req
);

    logic        line_adv;
    raster_evt_t evt;

    raster_dot_ctr #(.DOTS(DOTS)) u_dot (
        .clk      (clk),
        .rst      (rst),
        .ce       (ce),
        .dot      (dot),
        .line_adv (line_adv)
    );

    raster_line_ctr #(
        .LINES     (LINES),
        .VIS_LINES (VIS_LINES),
        .VBL_LINE  (VBL_LINE)
    ) u_line (
        .clk  (clk),
        .rst  (rst),
        .adv  (line_adv),
        .line (line),
        .evt  (evt)
    );

    raster_vblank u_vbl (
        .clk        (clk),
        .rst        (rst),
        .vbl_start  (evt.vbl_start),
        .frame_wrap (evt.frame_wrap),
        .rd_clr     (rd_clr),
        .nmi_en     (nmi_en),
        .flag       (vblank),
        .nmi        (nmi_req)
    );

    assign frame_done = evt.frame_end;
    assign visible    = in_range(32'(dot), PIX_FIRST, PIX_LAST)
                        && (32'(line) < VIS_LINES);

    p_done_dot_r4: assert property (@(posedge clk) disable iff (rst)
        frame_done |-> dot == '0);
    p_vis_bounds_r8: assert property (@(posedge clk) disable iff (rst)
        visible |-> (dot != '0) && (32'(line) < VIS_LINES));

endmodule

// File: tb/tb_raster_timer.sv
module tb_raster_timer;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ce = 1'b0;
    logic       nmi_en = 1'b0;
    logic       rd_clr = 1'b0;
    logic [8:0] dot;
    logic [8:0] line;
    logic       visible;
    logic       frame_done;
    logic       vblank;
    logic       nmi_req;

    int checks = 0;
    int failures = 0;
    int mdl_dot = 0;
    int mdl_line = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    raster_timer dut (
        .clk(clk), .rst(rst), .ce(ce), .nmi_en(nmi_en), .rd_clr(rd_clr),
        .dot(dot), .line(line), .visible(visible), .frame_done(frame_done),
        .vblank(vblank), .nmi_req(nmi_req)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        if (rst) begin
            mdl_dot = 0;
            mdl_line = 0;
        end else if (ce) begin
            if (mdl_dot == 340) begin
                mdl_dot = 0;
                mdl_line = (mdl_line == 260) ? 0 : mdl_line + 1;
            end else begin
                mdl_dot++;
            end
        end
        @(negedge clk);
    endtask

    task automatic run_to(input int l, input int d, input string req);
        while (!(mdl_line == l && mdl_dot == d)) step();
        chk(req, "dot", int'(dot), mdl_dot);
        chk(req, "line", int'(line), mdl_line);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        step();
        step();
        rst = 1'b0;
        chk("R9", "dot", int'(dot), 0);
        chk("R9", "line", int'(line), 0);
        chk("R9", "vblank", int'(vblank), 0);
        chk("R9", "nmi_req", int'(nmi_req), 0);
        chk("R9", "frame_done", int'(frame_done), 0);
        chk("R8", "visible at dot 0", int'(visible), 0);
    endtask

    task automatic t_ce_gate();
        ce = 1'b0;
        repeat (5) step();
        chk("R1", "dot held with ce low", int'(dot), 0);
        ce = 1'b1;
        repeat (3) step();
        chk("R1", "dot after three enables", int'(dot), 3);
        ce = 1'b0;
        repeat (4) step();
        chk("R1", "dot held again", int'(dot), 3);
        ce = 1'b1;
    endtask

    task automatic t_window_and_line_wrap();
        rst = 1'b1;
        step();
        rst = 1'b0;
        run_to(0, 1, "R8");
        chk("R8", "visible at dot 1", int'(visible), 1);
        run_to(0, 256, "R8");
        chk("R8", "visible at dot 256", int'(visible), 1);
        run_to(0, 257, "R8");
        chk("R8", "visible at dot 257", int'(visible), 0);
        run_to(0, 340, "R2");
        step();
        chk("R2", "dot after wrap", int'(dot), 0);
        chk("R2", "line after wrap", int'(line), 1);
        chk("R8", "visible at dot 0 of line 1", int'(visible), 0);
    endtask

    task automatic t_frame_done();
        run_to(239, 340, "R4");
        chk("R4", "strobe before line 240", int'(frame_done), 0);
        step();
        chk("R4", "line at strobe", int'(line), 240);
        chk("R4", "strobe at line 240", int'(frame_done), 1);
        step();
        chk("R4", "strobe one cycle only", int'(frame_done), 0);
        run_to(240, 100, "R8");
        chk("R8", "visible on line 240", int'(visible), 0);
    endtask

    task automatic t_set_wins_no_nmi();
        nmi_en = 1'b0;
        run_to(240, 340, "R5");
        chk("R5", "vblank before line 241", int'(vblank), 0);
        rd_clr = 1'b1;
        step();
        rd_clr = 1'b0;
        chk("R5", "line at vblank start", int'(line), 241);
        chk("R6", "set wins over same-edge clear", int'(vblank), 1);
        chk("R5", "no nmi while disabled", int'(nmi_req), 0);
        step();
        chk("R5", "vblank holds", int'(vblank), 1);
    endtask

    task automatic t_wrap_clear();
        run_to(260, 340, "R3");
        chk("R7", "vblank before wrap", int'(vblank), 1);
        step();
        chk("R3", "line after 260", int'(line), 0);
        chk("R3", "dot after 260", int'(dot), 0);
        chk("R7", "vblank cleared by wrap", int'(vblank), 0);
    endtask

    task automatic t_nmi_and_clear();
        nmi_en = 1'b1;
        run_to(240, 340, "R5");
        step();
        chk("R5", "vblank set", int'(vblank), 1);
        chk("R5", "nmi raised", int'(nmi_req), 1);
        step();
        chk("R5", "nmi one cycle", int'(nmi_req), 0);
        chk("R5", "vblank stays", int'(vblank), 1);
        rd_clr = 1'b1;
        step();
        rd_clr = 1'b0;
        chk("R6", "vblank cleared by read", int'(vblank), 0);
        step();
        chk("R6", "vblank stays clear", int'(vblank), 0);
    endtask

    task automatic t_mid_reset();
        rst = 1'b1;
        step();
        rst = 1'b0;
        chk("R9", "dot after mid reset", int'(dot), 0);
        chk("R9", "line after mid reset", int'(line), 0);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_ce_gate();
        t_window_and_line_wrap();
        t_frame_done();
        t_set_wins_no_nmi();
        t_wrap_clear();
        t_nmi_and_clear();
        t_mid_reset();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule